// File: doc/BRIEF.md
# Watchdog Timeout Register with Write-Protected Field

This block is a watchdog that counts down in steps of a slow timebase tick. The tick is a single-cycle enable in the system clock domain with a nominal period of 31.25 ms. Software sees one byte-wide control register. The register holds a strobe bit, a protect bit and a timeout field that counts ticks. A timeout of 1 is the shortest setting, and the largest 6-bit value gives roughly two seconds. A timeout of zero turns the watchdog off.

When the count runs out, the block raises a sticky flag. If the interrupt enable is high, it also raises an interrupt request. The flag clears when software reads the shared flags register, and that read is signalled to the block on an input. After expiry the counter rests at zero until it is strobed, so one timeout produces only one flag event. Ticks count only while the oscillator-running input is high, so stopping the oscillator freezes the watchdog.

The protect bit lets software restart the watchdog without disturbing the programmed interval. Software writes the strobe and the protect bit together, and the timeout field is left as it was.

Top module: `wdt_timer`

## Requirements
- R1: After reset the register reads {0, 0, RESET_TMO}, the flag is low, and the counter starts at RESET_TMO. The flag therefore rises on the RESET_TMO-th counted tick.
- R2: A write with bit 7 (strobe) set reloads the counter in that same cycle, and the flag rises on exactly the T-th counted tick after it. T is the timeout field that applies after the write. Bit 7 always reads back as 0.
- R3: A write with bit 6 (protect) set leaves the timeout field in bits 5:0 unchanged. The protect bit itself is stored and read back in bit 6.
- R4: A write with bits 7 and 6 both clear stores bits 5:0 as the new timeout. The counter reloads from that value at the next counted tick instead of decrementing there, so the flag rises on the (T+1)-th counted tick after the write.
- R5: While the timeout field is 0, the flag never rises, however many ticks arrive.
- R6: A tick while the oscillator-running input is low is ignored, and the count is frozen.
- R7: Once expired, the counter stays at 0. After the flag is cleared, further ticks do not raise it again until the next strobe.
- R8: A flags read clears the flag at the next clock edge. If expiry and a flags read fall in the same cycle, the flag is left set.
- R9: The interrupt request equals the flag gated by the interrupt enable, with no cycle of delay in the default configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle timebase enable (31.25 ms) |
| osc_run | input | 1 | High while the oscillator is running |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write byte: bit 7 strobe, bit 6 protect, bits 5:0 timeout |
| rd_data | output | 8 | Register readback: bit 7 zero, bit 6 protect, bits 5:0 timeout |
| flags_rd | input | 1 | Pulse marking a read of the flags register |
| irq_en | input | 1 | Interrupt enable for the watchdog flag |
| wdt_flag | output | 1 | Sticky watchdog timeout flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Register writes, strobes and flags reads act at the clock edge that samples them. Readback and flag changes are therefore checked at the following falling edge. Expiry is counted in ticks rather than cycles: the flag rises at the edge that takes the T-th counted tick after a strobe, or the (T+1)-th after a plain field write. Each test checks the flag low after one tick fewer than that and high right after the due tick. The interrupt request is combinational from the flag and the enable, so it is checked a fraction of a cycle after the enable changes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Byte layout of the control register (software visible)
   localparam int REG_W   = 8;
   localparam int STB_BIT = 7;
   localparam int WP_BIT  = 6;
   localparam int FLD_MAX = 6;   // widest timeout field the layout can carry

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_DEC  = 2'd1,
      CNT_LOAD = 2'd2
   } cnt_op_e;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
   import wdt_pkg::*;
#(
   parameter int TMO_W     = 6,
   parameter int RESET_TMO = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [TMO_W-1:0] tmo,
   output logic [TMO_W-1:0] load_val,
   output logic             strobe,
   output logic             tmo_wr,
   output logic [REG_W-1:0] rd_data
);
   logic wp_q;
   logic field_ok;

   assign field_ok = !wr_data[WP_BIT];
   assign strobe   = wr_en && wr_data[STB_BIT];
   assign tmo_wr   = wr_en && field_ok && !wr_data[STB_BIT];
   assign load_val = field_ok ? wr_data[TMO_W-1:0] : tmo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo  <= TMO_W'(RESET_TMO);
         wp_q <= 1'b0;
      end else if (wr_en) begin
         wp_q <= wr_data[WP_BIT];
         if (field_ok) tmo <= wr_data[TMO_W-1:0];
      end
   end

   always_comb begin
      rd_data              = '0;
      rd_data[WP_BIT]      = wp_q;
      rd_data[TMO_W-1:0]   = tmo;
   end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt
   import wdt_pkg::*;
#(
   parameter int TMO_W     = 6,
   parameter int RESET_TMO = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             strobe,
   input  logic [TMO_W-1:0] load_val,
   input  logic             tmo_wr,
   input  logic [TMO_W-1:0] tmo,
   output logic [TMO_W-1:0] cnt,
   output logic             pend,
   output logic             expire
);
   localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

   cnt_op_e op;

   always_comb begin
      op = CNT_HOLD;
      if (step) begin
         if (pend)             op = CNT_LOAD;
         else if (cnt != '0)   op = CNT_DEC;
      end
   end

   assign expire = !strobe && (op == CNT_DEC) && (cnt == ONE) && (tmo != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= TMO_W'(RESET_TMO);
         pend <= 1'b0;
      end else if (strobe) begin
         cnt  <= load_val;
         pend <= 1'b0;
      end else begin
         unique case (op)
            CNT_LOAD: begin
               cnt  <= tmo;
               pend <= tmo_wr;
            end
            CNT_DEC: begin
               cnt  <= cnt - ONE;
               pend <= pend | tmo_wr;
            end
            default: pend <= pend | tmo_wr;
         endcase
      end
   end
endmodule

// File: rtl/wdt_flag_irq.sv
module wdt_flag_irq #(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag && irq_en;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = flag && irq_en;
      end
   endgenerate
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pkg::*;
#(
   parameter int TMO_W          = 6,
   parameter int RESET_TMO      = 10,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             osc_run,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             flags_rd,
   input  logic             irq_en,
   output logic             wdt_flag,
   output logic             irq_req
);
   localparam int TMO_MAX = (1 << TMO_W) - 1;

   generate
      if (TMO_W < 1 || TMO_W > FLD_MAX) begin : g_bad_width
         $error("wdt_timer: TMO_W must lie in 1..%0d", FLD_MAX);
      end
      if (RESET_TMO < 0 || RESET_TMO > TMO_MAX) begin : g_bad_reset
         $error("wdt_timer: RESET_TMO must fit in TMO_W bits");
      end
   endgenerate

   logic [TMO_W-1:0] tmo;
   logic [TMO_W-1:0] load_val;
   logic [TMO_W-1:0] cnt;
   logic             strobe;
   logic             tmo_wr;
   logic             pend;
   logic             expire;
   logic             step;

   assign step = tick && osc_run;

   wdt_ctrl_reg #(.TMO_W(TMO_W), .RESET_TMO(RESET_TMO)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tmo(tmo), .load_val(load_val), .strobe(strobe), .tmo_wr(tmo_wr),
      .rd_data(rd_data)
   );

   wdt_down_cnt #(.TMO_W(TMO_W), .RESET_TMO(RESET_TMO)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .strobe(strobe),
      .load_val(load_val), .tmo_wr(tmo_wr), .tmo(tmo),
      .cnt(cnt), .pend(pend), .expire(expire)
   );

   wdt_flag_irq #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_flag (
      .clk(clk), .rst_n(rst_n), .set(expire), .clr(flags_rd),
      .irq_en(irq_en), .flag(wdt_flag), .irq(irq_req)
   );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
   parameter int TMO_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             osc_run,
   input logic             wr_en,
   input logic [7:0]       wr_data,
   input logic [7:0]       rd_data,
   input logic             flags_rd,
   input logic             wdt_flag,
   input logic [TMO_W-1:0] cnt,
   input logic             pend
);
   p_strobe_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7] == 1'b0);

   p_protect_keeps_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[6]) |=> $stable(rd_data[TMO_W-1:0]));

   p_disabled_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[TMO_W-1:0] == '0 && !wdt_flag && !wr_en) |=> !wdt_flag);

   p_flag_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_flag) |-> $past(tick && osc_run));

   p_rest_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !pend && !wr_en) |=> cnt == '0);

   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_rd && !(tick && osc_run)) |=> !wdt_flag);
endmodule

bind wdt_timer wdt_timer_chk #(.TMO_W(TMO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .osc_run(osc_run),
   .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
   .flags_rd(flags_rd), .wdt_flag(wdt_flag), .cnt(cnt), .pend(pend)
);

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;
   localparam int RST_TMO = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       osc_run = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       flags_rd = 1'b0;
   logic       irq_en = 1'b0;
   logic       wdt_flag;
   logic       irq_req;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   wdt_timer #(.TMO_W(6), .RESET_TMO(RST_TMO)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .osc_run(osc_run),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .flags_rd(flags_rd), .irq_en(irq_en), .wdt_flag(wdt_flag),
      .irq_req(irq_req)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic reg_write(input logic [7:0] d);
      @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic read_flags();
      @(negedge clk) flags_rd = 1'b1;
      @(negedge clk) flags_rd = 1'b0;
   endtask

   task automatic t_reset_r1();
      check("R1 reset readback", rd_data, 8'(RST_TMO));
      check("R1 reset flag", {7'b0, wdt_flag}, 8'h00);
      ticks(RST_TMO - 1);
      check("R1 flag before timeout", {7'b0, wdt_flag}, 8'h00);
      ticks(1);
      check("R1 flag at timeout", {7'b0, wdt_flag}, 8'h01);
   endtask

   task automatic t_clear_rest_r7_r8();
      ticks(3);
      check("R7 flag stays set", {7'b0, wdt_flag}, 8'h01);
      read_flags();
      check("R8 flags read clears", {7'b0, wdt_flag}, 8'h00);
      ticks(20);
      check("R7 no second flag", {7'b0, wdt_flag}, 8'h00);
   endtask

   task automatic t_strobe_r2();
      reg_write(8'h85);
      check("R2 strobe reads zero", rd_data, 8'h05);
      ticks(4);
      check("R2 flag before T", {7'b0, wdt_flag}, 8'h00);
      ticks(1);
      check("R2 flag at T", {7'b0, wdt_flag}, 8'h01);
      read_flags();
   endtask

   task automatic t_protect_r3();
      reg_write(8'hC3);
      check("R3 field kept, protect read", rd_data, 8'h45);
      ticks(4);
      check("R3 reload uses kept field", {7'b0, wdt_flag}, 8'h00);
      ticks(1);
      check("R3 flag at kept T", {7'b0, wdt_flag}, 8'h01);
      read_flags();
   endtask

   task automatic t_plain_write_r4();
      reg_write(8'h02);
      check("R4 new field readback", rd_data, 8'h02);
      ticks(2);
      check("R4 flag before T+1", {7'b0, wdt_flag}, 8'h00);
      ticks(1);
      check("R4 flag at T+1", {7'b0, wdt_flag}, 8'h01);
      read_flags();
   endtask

   task automatic t_osc_r6();
      reg_write(8'h82);
      osc_run = 1'b0;
      ticks(10);
      check("R6 frozen without oscillator", {7'b0, wdt_flag}, 8'h00);
      @(negedge clk) osc_run = 1'b1;
      ticks(1);
      check("R6 resume count", {7'b0, wdt_flag}, 8'h00);
      ticks(1);
      check("R6 flag after resume", {7'b0, wdt_flag}, 8'h01);
      read_flags();
   endtask

   task automatic t_disable_r5();
      reg_write(8'h80);
      check("R5 zero field readback", rd_data, 8'h00);
      ticks(70);
      check("R5 no flag when disabled", {7'b0, wdt_flag}, 8'h00);
      reg_write(8'h84);
      ticks(2);
      reg_write(8'h00);
      ticks(5);
      check("R5 disable mid-count", {7'b0, wdt_flag}, 8'h00);
   endtask

   task automatic t_irq_r9();
      irq_en = 1'b0;
      reg_write(8'h81);
      ticks(1);
      check("R9 flag set", {7'b0, wdt_flag}, 8'h01);
      check("R9 irq masked", {7'b0, irq_req}, 8'h00);
      irq_en = 1'b1;
      #1;
      check("R9 irq enabled", {7'b0, irq_req}, 8'h01);
      read_flags();
      check("R9 irq drops with flag", {7'b0, irq_req}, 8'h00);
      irq_en = 1'b0;
   endtask

   task automatic t_set_wins_r8();
      reg_write(8'h81);
      @(negedge clk) begin tick = 1'b1; flags_rd = 1'b1; end
      @(negedge clk) begin tick = 1'b0; flags_rd = 1'b0; end
      check("R8 set wins over clear", {7'b0, wdt_flag}, 8'h01);
      read_flags();
      check("R8 later clear", {7'b0, wdt_flag}, 8'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_clear_rest_r7_r8();
      t_strobe_r2();
      t_protect_r3();
      t_plain_write_r4();
      t_osc_r6();
      t_disable_r5();
      t_irq_r9();
      t_set_wins_r8();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule